// File: doc/BRIEF.md
# Galois Carry-Feedback Shift Register

This block is a feedback-with-carry shift register in Galois form. Each clock with the step enable set, it emits one pseudorandom bit and moves to its next state. The bit stream is the 2-adic expansion of the rational number p/q. Here q = 1 − 2·D is a negative odd connection integer. The value p = m + 2·c is set by the main register m and the carry register c. The tap constant D is a compile-time parameter. Its top bit must be set, so that 2^N < |q| < 2^(N+1).

The cells of the main register sit in a chain. On each step every cell takes the value of the cell above it. At a tap position i below the top, where D has a one, the cell instead adds three bits: the cell above it, its own stored carry and the bit leaving at position 0. The cell keeps the low bit of that sum and stores the high bit as its new carry. The top cell takes the leaving bit, and it has no carry. A load strobe puts a chosen (m, c) pair into the register. The strobe wins over the step enable when both are set.

The block is meant to be the state element of a larger keystream generator. It exposes its whole state so that a filter or combiner around it can read any cell.

Top module: `fcsr_galois`

## Requirements
- R1: When rst_ni is low, both state registers clear asynchronously: m_o = 0, c_o = 0 and bit_o = 0.
- R2: A clock edge with load_i high sets m_o to load_m_i and sets the carry to load_c_i, but only at carry cells. This happens whatever the value of step_i.
- R3: bit_o always shows m_o[0]. With step_i high and load_i low, the bits seen on successive cycles form the 2-adic expansion of p/q. Here q = 1 − 2·TAP_D, and p is computed from the state after the load.
- R4: Take p = m_o + 2·c_o, with c_o bit i weighted 2^i. Each step changes p into (p + m_o[0]·|q|) / 2.
- R5: Carry cells exist only at positions i < N_BITS−1 where TAP_D[i] = 1. Every other c_o bit reads 0 at all times, even after a load that sets it.
- R6: With both load_i and step_i low, m_o and c_o keep their values.
- R7: An all-zero state stays all-zero under stepping, and bit_o stays 0.
- R8: The defaults are N_BITS = 8 and TAP_D = 174, so q = −347. With these defaults and 0 < p < 347, the output repeats with a period of exactly 346 bits.
- R9: The cell arithmetic works as follows. A tap cell i takes the sum m[i+1] + c[i] + m[0], keeping its low bit and sending its high bit to the carry. A non-tap cell copies m[i+1]. The top cell takes m[0].
- R10: When p equals |q|, the value p/q is −1, so every output bit is 1 and the state does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe; wins over step_i |
| step_i | input | 1 | Advance the register by one step |
| load_m_i | input | N_BITS | Main register value to load |
| load_c_i | input | N_BITS-1 | Carry value to load (bits outside carry cells are dropped) |
| bit_o | output | 1 | Serial output bit, equal to m_o[0] |
| m_o | output | N_BITS | Main register state |
| c_o | output | N_BITS-1 | Carry state (zero at positions without a carry cell) |

## Verification
The bench uses four start states, each aimed at a different fault. The first is p = 1, run for more than one full period; it checks the long-run arithmetic and the 346-bit period. The second is a load with every carry bit set, including the positions with no carry cell; it shows whether carries are kept only where taps exist. The third is p = |q|, which must give a fixed point of all ones and so catches a carry that is dropped or doubled. The fourth is the zero state, which catches any feedback that appears from nothing. Hold cycles, a load that arrives together with a step, and a reset in the middle of a run check how the controls are ordered.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;

  function automatic int unsigned count_ones(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/fcsr_shift_cell.sv
module fcsr_shift_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  input  logic ld_m_i,
  input  logic src_i,
  output logic m_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     m_o <= 1'b0;
    else if (load_i) m_o <= ld_m_i;
    else if (step_i) m_o <= src_i;
  end

endmodule

// File: rtl/fcsr_carry_cell.sv
module fcsr_carry_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  input  logic ld_m_i,
  input  logic ld_c_i,
  input  logic up_i,
  input  logic fb_i,
  output logic m_o,
  output logic c_o
);

  logic [1:0] sum;

  // integer add of three bits: upper cell, stored carry, feedback
  assign sum = {1'b0, up_i} + {1'b0, c_o} + {1'b0, fb_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_o <= 1'b0;
      c_o <= 1'b0;
    end else if (load_i) begin
      m_o <= ld_m_i;
      c_o <= ld_c_i;
    end else if (step_i) begin
      m_o <= sum[0];
      c_o <= sum[1];
    end
  end

endmodule

// File: rtl/fcsr_galois.sv
module fcsr_galois #(
  parameter int unsigned         N_BITS = 8,
  parameter logic [N_BITS-1:0]   TAP_D  = 8'd174
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [N_BITS-1:0] load_m_i,
  input  logic [N_BITS-2:0] load_c_i,
  output logic              bit_o,
  output logic [N_BITS-1:0] m_o,
  output logic [N_BITS-2:0] c_o
);

  localparam int unsigned TOP = N_BITS - 1;

  logic [N_BITS-1:0] m_q;
  logic [N_BITS-2:0] c_q;

  for (genvar i = 0; i < N_BITS; i++) begin : g_cell
    if (i == TOP) begin : g_top
      // top tap: upper neighbour is zero, so no carry can form
      fcsr_shift_cell u_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .load_i(load_i),
        .step_i(step_i),
        .ld_m_i(load_m_i[i]),
        .src_i (m_q[0]),
        .m_o   (m_q[i])
      );
    end else if (TAP_D[i]) begin : g_tap
      fcsr_carry_cell u_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .load_i(load_i),
        .step_i(step_i),
        .ld_m_i(load_m_i[i]),
        .ld_c_i(load_c_i[i]),
        .up_i  (m_q[i+1]),
        .fb_i  (m_q[0]),
        .m_o   (m_q[i]),
        .c_o   (c_q[i])
      );
    end else begin : g_plain
      fcsr_shift_cell u_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .load_i(load_i),
        .step_i(step_i),
        .ld_m_i(load_m_i[i]),
        .src_i (m_q[i+1]),
        .m_o   (m_q[i])
      );
      assign c_q[i] = 1'b0;
    end
  end

  assign bit_o = m_q[0];
  assign m_o   = m_q;
  assign c_o   = c_q;

endmodule

// File: rtl/fcsr_galois_chk.sv
module fcsr_galois_chk #(
  parameter int unsigned         N_BITS = 8,
  parameter logic [N_BITS-1:0]   TAP_D  = 8'd174
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              step_i,
  input logic [N_BITS-1:0] load_m_i,
  input logic [N_BITS-2:0] load_c_i,
  input logic              bit_o,
  input logic [N_BITS-1:0] m_o,
  input logic [N_BITS-2:0] c_o
);

  localparam int unsigned PW      = N_BITS + 3;
  localparam int unsigned N_CARRY = fcsr_pkg::count_ones(64'(TAP_D)) - 1;
  localparam logic [PW-1:0] Q_ABS = (PW'(TAP_D) << 1) - PW'(1);
  localparam logic [N_BITS-2:0] C_MASK = TAP_D[N_BITS-2:0];

  logic [PW-1:0] p_now, p_adv;

  always_comb begin
    p_now = PW'(m_o) + (PW'(c_o) << 1);
    p_adv = (p_now + (m_o[0] ? Q_ABS : '0)) >> 1;
  end

  assert_load_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (m_o == $past(load_m_i)) && (c_o == ($past(load_c_i) & C_MASK)));

  assert_rational_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (p_now == $past(p_adv)));

  assert_carry_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(c_o) <= N_CARRY);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> ($stable(m_o) && $stable(c_o)));

  assert_zero_fixed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && m_o == '0 && c_o == '0) |=> (m_o == '0 && c_o == '0 && !bit_o));

  assert_top_feed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (m_o[N_BITS-1] == $past(bit_o)));

endmodule

bind fcsr_galois fcsr_galois_chk #(.N_BITS(N_BITS), .TAP_D(TAP_D)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .step_i  (step_i),
  .load_m_i(load_m_i),
  .load_c_i(load_c_i),
  .bit_o   (bit_o),
  .m_o     (m_o),
  .c_o     (c_o)
);

// File: tb/tb_fcsr_galois.sv
module tb_fcsr_galois;

  localparam int unsigned N     = 8;
  localparam int          D     = 174;
  localparam int          Q_ABS = 2 * D - 1;   // 347
  localparam int          PER   = Q_ABS - 1;   // 346
  localparam logic [N-2:0] C_MASK = 7'(D);

  typedef struct {
    int    p;
    string tag_b;
    string tag_p;
    bit    rec;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic         step_i = 1'b0;
  logic [N-1:0] load_m_i = '0;
  logic [N-2:0] load_c_i = '0;
  logic         bit_o;
  logic [N-1:0] m_o;
  logic [N-2:0] c_o;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    p_mdl  = 0;
  item_t sb_q[$];
  bit    obs[$];

  always #4 clk = ~clk;

  fcsr_galois dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .step_i(step_i),
    .load_m_i(load_m_i), .load_c_i(load_c_i),
    .bit_o(bit_o), .m_o(m_o), .c_o(c_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected post-edge state
  task automatic cyc(input bit ld, input bit st, input logic [N-1:0] lm,
                     input logic [N-2:0] lc, input string tb_, input string tp, input bit rec);
    item_t it;
    @(negedge clk);
    load_i = ld; step_i = st; load_m_i = lm; load_c_i = lc;
    if (ld)      p_mdl = int'(lm) + 2 * int'(lc & C_MASK);
    else if (st) p_mdl = (p_mdl + (p_mdl % 2) * Q_ABS) / 2;
    it.p = p_mdl; it.tag_b = tb_; it.tag_p = tp; it.rec = rec;
    sb_q.push_back(it);
    @(posedge clk);
  endtask

  task automatic quiet();
    @(negedge clk);
    load_i = 1'b0; step_i = 1'b0;
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        int    p_act;
        it = sb_q.pop_front();
        p_act = int'(m_o) + 2 * int'(c_o);
        check(bit_o == 1'(it.p % 2), it.tag_b, int'(bit_o), it.p % 2);
        check(p_act == it.p, it.tag_p, p_act, it.p);
        check((c_o & ~C_MASK) == '0, "R5", int'(c_o), int'(c_o & C_MASK));
        if (it.rec) obs.push_back(bit_o);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #10;
    check(m_o == '0 && c_o == '0 && bit_o == 1'b0, "R1", int'(m_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2: load with step also high, load must win; then R3/R4 stepping for > one period
    cyc(1'b1, 1'b1, 8'd1, 7'd0, "R2", "R2", 1'b1);
    for (int k = 0; k < 400; k++) cyc(1'b0, 1'b1, '0, '0, "R3", "R4", 1'b1);
    quiet();

    // R8: period 346 from p = 1
    for (int k = 0; k + PER < obs.size(); k++)
      check(obs[k] == obs[k+PER], "R8", int'(obs[k+PER]), int'(obs[k]));
    // no shorter period of 173 (half) or 2
    check(obs[0:172] != obs[173:345], "R8", 0, 1);

    // R6: hold
    for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0, 8'hFF, 7'h7F, "R6", "R6", 1'b0);

    // R5/R9: all carry bits requested, only tap cells keep them
    cyc(1'b1, 1'b0, 8'hA5, 7'h7F, "R5", "R5", 1'b0);
    for (int k = 0; k < 100; k++) cyc(1'b0, 1'b1, '0, '0, "R9", "R4", 1'b0);

    // R10: p = |q| fixed point of all ones
    cyc(1'b1, 1'b0, 8'hFF, 7'h2E, "R2", "R2", 1'b0);
    for (int k = 0; k < 20; k++) cyc(1'b0, 1'b1, '0, '0, "R10", "R10", 1'b0);

    // R7: zero state under stepping
    cyc(1'b1, 1'b1, 8'h00, 7'h00, "R2", "R2", 1'b0);
    for (int k = 0; k < 20; k++) cyc(1'b0, 1'b1, '0, '0, "R7", "R7", 1'b0);

    // R1: asynchronous reset in the middle of a run
    cyc(1'b1, 1'b0, 8'h5A, 7'h2E, "R2", "R2", 1'b0);
    for (int k = 0; k < 7; k++) cyc(1'b0, 1'b1, '0, '0, "R3", "R4", 1'b0);
    quiet();
    #1 rst_ni = 1'b0;
    #1 check(m_o == '0 && c_o == '0 && bit_o == 1'b0, "R1", int'(m_o) + int'(c_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    p_mdl = 0;
    cyc(1'b0, 1'b1, '0, '0, "R7", "R7", 1'b0);
    quiet();
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule